// File: doc/BRIEF.md
# Coded-Field GPIO Output Register

This block is a single 32-bit control register that drives a small bank of output pins. Each pin has its own field of several bits inside the register, not one bit. Writing one command code into a pin's field raises that pin. Writing a second command code lowers it. Any other value in the field leaves the pin alone. This lets software change one pin without a read-modify-write: fields that it writes as zero have no effect.

The register has a 4-byte address window. The following are build-time parameters:

- the number of lines;
- the field width;
- the bit offset of the first field;
- the two command codes, which all lines share;
- the per-line reset value.

Line n owns bits [FIRST_SHIFT + n*FIELD_W +: FIELD_W]. In the default build, line 0 sits at bits 6:5 and line 1 at bits 8:7. Bits 4:0 and 31:9 are unused.

The register port is a plain synchronous register access. It has no valid/ready handshake and no back-pressure, and a write is accepted in every cycle that the write enable is high and the address hits. Reads are combinational from the address. The pins are plain level outputs.

Top module: `coded_gpio_out`

## Requirements
- R1: A synchronous active-high reset loads each pin with its RESET_VAL bit (default 1 for both lines). Reset takes priority over a write in the same cycle.
- R2: A write that hits, with the raise code (default 2) in a line's field, drives that pin to 1 on the next rising clock edge.
- R3: A write that hits, with the lower code (default 3) in a line's field, drives that pin to 0 on the next rising clock edge.
- R4: A line's pin keeps its value when its field holds any code other than the raise or lower code (default 0 or 1).
- R5: One write updates every line according to its own field: line n is decoded from bits [5+2n +: 2] by default, so line 0 uses bits 6:5 and line 1 uses bits 8:7.
- R6: Register bits outside all line fields (default 4:0 and 31:9) have no effect on any pin.
- R7: A read at the register address returns, in each line's field, the raise code if the pin is 1 and the lower code if it is 0. All other bits read as 0.
- R8: The block responds only when addr[ADDR_W-1:2] matches BASE_ADDR[ADDR_W-1:2], and addr[1:0] is ignored. A write that misses changes no pin, and a read that misses returns 0.
- R9: Pins change only at the rising edge that accepts a write. They do not change before that edge, and without a write they hold their value.
- R10: Elaboration fails if the fields do not fit in 32 bits, if the two codes are equal, or if a code does not fit in FIELD_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (12) | Byte address of the access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data holding the per-line command fields |
| rd_data | output | 32 | Combinational read data |
| pins | output | NUM_LINES (2) | Output pin levels, one per line |

## Verification
The bench builds the block with its default parameters:

- two lines of 2-bit fields starting at bit 5;
- codes 2 and 3;
- both reset values 1;
- base address 0x0A0.

With this build, the non-command codes 0 and 1 are reachable. Unused bits exist both below and above the fields, so the ignore rule is tested on each side. A read value can be checked bit for bit against the field positions. Because the two lines sit next to each other, a wrong field offset or width shows up as one line reacting to the other's code.

// File: rtl/coded_gpio_pkg.sv
package coded_gpio_pkg;

  localparam int unsigned REG_W = 32;

  // Mask of all bits that belong to some line field.
  function automatic logic [REG_W-1:0] field_mask(input int unsigned shift,
                                                  input int unsigned width,
                                                  input int unsigned lines);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < REG_W; b++) begin
      if (b >= shift && b < shift + width * lines) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/coded_gpio_addr_match.sv
module coded_gpio_addr_match #(
  parameter int unsigned          ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 12'h0A0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // Word-granular compare: the low two byte-offset bits are not decoded.
  logic unused_low;
  assign unused_low = ^addr[1:0];
  assign hit = (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]);
endmodule

// File: rtl/coded_gpio_decode.sv
module coded_gpio_decode
  import coded_gpio_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 2,
  parameter int unsigned FIELD_W     = 2,
  parameter int unsigned FIRST_SHIFT = 5,
  parameter int unsigned CODE_SET    = 2,
  parameter int unsigned CODE_CLR    = 3
) (
  input  logic                 wr_en,
  input  logic                 hit,
  input  logic [REG_W-1:0]     wr_data,
  output logic [NUM_LINES-1:0] set_cmd,
  output logic [NUM_LINES-1:0] clr_cmd
);
  localparam logic [FIELD_W-1:0] SET_C = FIELD_W'(CODE_SET);
  localparam logic [FIELD_W-1:0] CLR_C = FIELD_W'(CODE_CLR);
  localparam logic [REG_W-1:0]   MASK  = field_mask(FIRST_SHIFT, FIELD_W, NUM_LINES);

  // Bits outside every field are deliberately ignored.
  logic unused_bits;
  assign unused_bits = ^(wr_data & ~MASK);

  logic accept;
  assign accept = wr_en & hit;

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_line
      logic [FIELD_W-1:0] fld;
      assign fld        = wr_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W];
      assign set_cmd[n] = accept && (fld == SET_C);
      assign clr_cmd[n] = accept && (fld == CLR_C);
    end
  endgenerate
endmodule

// File: rtl/coded_gpio_line.sv
module coded_gpio_line #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/coded_gpio_readback.sv
module coded_gpio_readback
  import coded_gpio_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 2,
  parameter int unsigned FIELD_W     = 2,
  parameter int unsigned FIRST_SHIFT = 5,
  parameter int unsigned CODE_SET    = 2,
  parameter int unsigned CODE_CLR    = 3
) (
  input  logic                 hit,
  input  logic [NUM_LINES-1:0] pins,
  output logic [REG_W-1:0]     rd_data
);
  localparam logic [FIELD_W-1:0] SET_C = FIELD_W'(CODE_SET);
  localparam logic [FIELD_W-1:0] CLR_C = FIELD_W'(CODE_CLR);

  logic [REG_W-1:0] image;

  always_comb begin
    image = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      image[FIRST_SHIFT + n*FIELD_W +: FIELD_W] = pins[n] ? SET_C : CLR_C;
    end
  end

  assign rd_data = hit ? image : '0;
endmodule

// File: rtl/coded_gpio_out.sv
module coded_gpio_out
  import coded_gpio_pkg::*;
#(
  parameter int unsigned          NUM_LINES   = 2,
  parameter int unsigned          FIELD_W     = 2,
  parameter int unsigned          FIRST_SHIFT = 5,
  parameter int unsigned          CODE_SET    = 2,
  parameter int unsigned          CODE_CLR    = 3,
  parameter logic [NUM_LINES-1:0] RESET_VAL   = '1,
  parameter int unsigned          ADDR_W      = 12,
  parameter logic [ADDR_W-1:0]    BASE_ADDR   = 12'h0A0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  output logic [NUM_LINES-1:0] pins
);
  localparam int unsigned FIELD_END = FIRST_SHIFT + NUM_LINES * FIELD_W;
  localparam int unsigned CODE_LIM  = 1 << FIELD_W;

  // R10: configuration checks at elaboration
  generate
    if (FIELD_END > REG_W) begin : g_bad_fit
      $error("coded_gpio_out: line fields exceed the 32-bit register");
    end
    if (CODE_SET == CODE_CLR) begin : g_bad_codes
      $error("coded_gpio_out: raise and lower codes must differ");
    end
    if (CODE_SET >= CODE_LIM || CODE_CLR >= CODE_LIM) begin : g_bad_width
      $error("coded_gpio_out: a command code does not fit in FIELD_W bits");
    end
  endgenerate

  logic                 hit;
  logic [NUM_LINES-1:0] set_cmd;
  logic [NUM_LINES-1:0] clr_cmd;

  coded_gpio_addr_match #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_match (
    .addr(addr), .hit(hit)
  );

  coded_gpio_decode #(
    .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .FIRST_SHIFT(FIRST_SHIFT),
    .CODE_SET(CODE_SET), .CODE_CLR(CODE_CLR)
  ) u_decode (
    .wr_en(wr_en), .hit(hit), .wr_data(wr_data),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd)
  );

  genvar n;
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_lines
      coded_gpio_line #(.RST_VAL(RESET_VAL[n])) u_line (
        .clk(clk), .rst(rst), .set_i(set_cmd[n]), .clr_i(clr_cmd[n]),
        .q_o(pins[n])
      );
    end
  endgenerate

  coded_gpio_readback #(
    .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .FIRST_SHIFT(FIRST_SHIFT),
    .CODE_SET(CODE_SET), .CODE_CLR(CODE_CLR)
  ) u_readback (
    .hit(hit), .pins(pins), .rd_data(rd_data)
  );

  // R1: the cycle after reset shows the configured defaults
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pins == RESET_VAL));

  // R8: an access outside the window never returns data
  assert_miss_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:2] != BASE_ADDR[ADDR_W-1:2]) |-> (rd_data == '0));

  // R8: a write outside the window leaves every pin as it was
  assert_miss_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (addr[ADDR_W-1:2] != BASE_ADDR[ADDR_W-1:2]) |=> $stable(pins));

  // R7: each read field reflects its pin level
  generate
    for (n = 0; n < NUM_LINES; n++) begin : g_rd_chk
      assert_readback_field_R7: assert property (@(posedge clk) disable iff (rst)
        (addr[ADDR_W-1:2] == BASE_ADDR[ADDR_W-1:2]) |->
        (rd_data[FIRST_SHIFT + n*FIELD_W +: FIELD_W] ==
         (pins[n] ? FIELD_W'(CODE_SET) : FIELD_W'(CODE_CLR))));
    end
  endgenerate
endmodule

// File: tb/test_coded_gpio_out.sv
module test_coded_gpio_out;
  localparam int CLK_PERIOD = 10;
  localparam int NL    = 2;
  localparam int FW    = 2;
  localparam int FS    = 5;
  localparam int SETC  = 2;
  localparam int CLRC  = 3;
  localparam logic [11:0] BASE = 12'h0A0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = BASE;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [NL-1:0] pins;

  logic [NL-1:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  coded_gpio_out i_coded_gpio_out (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pins(pins)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [NL-1:0] m);
    logic [31:0] r = '0;
    for (int n = 0; n < NL; n++)
      r = r | (32'(m[n] ? SETC : CLRC) << (FS + FW*n));
    return r;
  endfunction

  function automatic logic [NL-1:0] apply(input logic [NL-1:0] m, input logic [31:0] d);
    logic [NL-1:0] r = m;
    for (int n = 0; n < NL; n++) begin
      int f = int'((d >> (FS + FW*n)) & 32'h3);
      if (f == SETC) r[n] = 1'b1;
      else if (f == CLRC) r[n] = 1'b0;
    end
    return r;
  endfunction

  // Write through the port; pins are sampled at the falling edge after capture.
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit hits);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; addr = BASE;
    if (hits) model = apply(model, d);
  endtask

  task automatic check_state(input string req);
    #1;
    chk(req, 32'(pins), 32'(model));
    chk({req, " readback R7"}, rd_data, exp_rd(model));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", 32'(pins), 32'h3);
    rst = 1'b0;
    model = 2'b11;
    check_state("R1 after reset");
    chk("R7 default image", rd_data, 32'h0000_0140);
  endtask

  task automatic t_clear_set;
    wr(BASE, 32'h0000_0060, 1);        // line0 lower, line1 code 0
    check_state("R3 lower line0");
    chk("R3 pins=10", 32'(pins), 32'h2);
    chk("R7 image", rd_data, 32'h0000_0160);
    wr(BASE, 32'h0000_0040, 1);        // line0 raise
    check_state("R2 raise line0");
    chk("R2 pins=11", 32'(pins), 32'h3);
  endtask

  task automatic t_multi;
    wr(BASE, 32'h0000_01E0, 1);        // both lower
    check_state("R5 both lower");
    chk("R5 pins=00", 32'(pins), 32'h0);
    chk("R7 all lower image", rd_data, 32'h0000_01E0);
    wr(BASE, 32'h0000_0160, 1);        // line1 raise, line0 lower
    check_state("R5 line1 raise");
    chk("R5 pins=10", 32'(pins), 32'h2);
    wr(BASE, 32'h0000_00C0, 1);        // line0 raise(2), line1 code 1
    chk("R5 pins=11", 32'(pins), 32'h3);
  endtask

  task automatic t_other_codes;
    wr(BASE, 32'h0000_0060, 1);        // pins -> 10
    wr(BASE, 32'h0000_00A0, 1);        // line0 code 1, line1 code 1
    check_state("R4 code1 hold");
    chk("R4 pins held 10", 32'(pins), 32'h2);
    wr(BASE, 32'h0000_0000, 1);        // codes 0
    chk("R4 code0 hold", 32'(pins), 32'h2);
  endtask

  task automatic t_unused_bits;
    wr(BASE, 32'hFFFF_FE1F, 1);        // all fields 0, every other bit 1
    check_state("R6 unused bits");
    chk("R6 pins unchanged", 32'(pins), 32'h2);
    wr(BASE, 32'hFFFF_FE1F | 32'h40, 1); // plus raise line0
    chk("R6 raise through noise", 32'(pins), 32'h3);
  endtask

  task automatic t_address;
    wr(BASE + 12'h004, 32'h0000_01E0, 0);
    chk("R8 miss write", 32'(pins), 32'h3);
    @(negedge clk); addr = BASE + 12'h004; #1;
    chk("R8 miss read zero", rd_data, 32'h0);
    addr = BASE | 12'h003; #1;
    chk("R8 low bits ignored on read", rd_data, exp_rd(model));
    wr(BASE | 12'h002, 32'h0000_0180, 1); // lower line1 via offset 2
    chk("R8 low bits ignored on write", 32'(pins), 32'h1);
  endtask

  task automatic t_timing;
    @(negedge clk);
    addr = BASE; wr_en = 1'b1; wr_data = 32'h0000_0060; // lower line0
    #1;
    chk("R9 before edge", 32'(pins), 32'h1);
    @(posedge clk); #1;
    chk("R9 after edge", 32'(pins), 32'h0);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    model = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9 idle hold", 32'(pins), 32'h0);
  endtask

  task automatic t_reset_priority;
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; addr = BASE; wr_data = 32'h0000_01E0;
    @(negedge clk);
    chk("R1 reset beats write", 32'(pins), 32'h3);
    rst = 1'b0; wr_en = 1'b0; wr_data = '0;
    model = 2'b11;
    check_state("R1 after second reset");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model = 2'b11;
    t_reset();
    t_clear_set();
    t_multi();
    t_other_codes();
    t_unused_bits();
    t_address();
    t_timing();
    t_reset_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule